// File: doc/BRIEF.md
# Serial Configuration Register Bank

A write-only, three-wire serial slave that loads a bank of four 32-bit configuration registers. A host lowers the latch-enable line, shifts a 32-bit word in with the most significant bit first, and raises latch-enable again. On that rising edge, the block copies the word into the register that the word's own two low bits name. The address travels inside the data, so every stored word keeps its address bits in bits 1:0. The bank has no read path, no acknowledge and no handshake.

The three serial pins and the active-low power-down pin are brought into the system clock domain through two-stage synchronizers. Each serial level must therefore stay stable for at least three system clock cycles. A word is committed only when exactly 32 serial clock rises were seen during the low phase of latch-enable. A frame of any other length leaves every register unchanged and sets a sticky error flag. Asserting power-down holds every register at its default value and clears the flag.

The bank drives the raw register contents and a set of decoded control fields (divider values, mux selects, lock and hold settings) to the surrounding clocking logic. Divider fields hold the divide ratio minus one.

Top module: `cfg_serial_bank`

## Requirements
- R1: While the synchronized latch-enable is low, each rising serial clock edge shifts `sdata_i` into the word, so the first bit sent lands in bit 31 of the committed word.
- R2: On commit, bits 1:0 of the word select the register (00→reg 0, 01→reg 1, 10→reg 2, 11→reg 3). Only that register changes; the other three keep their contents.
- R3: Serial clock edges while latch-enable is high are ignored: no register changes and the error flag stays as it was.
- R4: A falling edge of latch-enable starts a new frame with a cleared bit count, so a correct frame after a bad one commits normally.
- R5: A word is committed on the rising edge of latch-enable only if exactly 32 serial clock rises were counted. Any other count (for example 31 or 33) leaves all registers unchanged and sets `frame_err_o`. The flag stays at 1 until reset or power-down.
- R6: After reset, the registers hold 0x0007F1FC, 0x0000007D, 0xDB6DB4A2 and 0x00000027 (reg 0 to reg 3), and `frame_err_o` is 0.
- R7: While `pd_ni` is low, every register is held at its R6 default, `frame_err_o` is cleared, and frames sent during that time are not stored.
- R8: In reg 3 only bits 0–6, 9 and 11 are stored (mask 0x00000A7F). All other bits always read 0.
- R9: The decoded outputs are taken from these fields:
  - `ref_div_m1_o` = reg0[11:2] and `fb_div_m1_o` = reg0[23:12], each holding the ratio minus one (the default 127 means divide by 128).
  - `ref_auto_o` = reg0[30].
  - `fb_mux_o` = reg2[12:10].
  - `out_mux_o` = reg2[27:13], three bits per output pair, pair 0 lowest.
  - `lock_win_o` = reg3[3:2] and `lock_cnt_o` = reg3[5:4].
  - `hold_en_o` = reg3[9].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_ni | input | 1 | Active-low power-down; forces register defaults |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| sdata_i | input | 1 | Serial data, MSB first |
| le_i | input | 1 | Latch enable; low during a frame, rising edge commits |
| cfg_o | output | 4x32 | Raw contents of the four registers |
| ref_div_m1_o | output | 10 | Reference divider ratio minus one |
| fb_div_m1_o | output | 12 | Feedback divider ratio minus one |
| ref_auto_o | output | 1 | Automatic reference selection enable |
| fb_mux_o | output | 3 | Feedback divider select |
| out_mux_o | output | 15 | Output pair divider selects, 3 bits per pair |
| lock_win_o | output | 2 | Lock-detect window code |
| lock_cnt_o | output | 2 | Lock-detect cycle count code |
| hold_en_o | output | 1 | Hold-over function enable |
| frame_err_o | output | 1 | Sticky flag for a frame with a wrong bit count |

## Verification
The hardest conditions to reach from the pins are frames whose length is off by one in either direction, and serial activity outside a frame. Both must leave the bank untouched while still being visible through the sticky flag. The bench drives every frame through one bit-level task that takes an explicit bit count. It sends 31-bit and 33-bit frames that carry valid address bits, and toggles the serial clock with data while latch-enable is high. It then shows that a following correct frame still commits. A frame sent while power-down is held low checks that the forced defaults win over a commit.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned ADDR_W   = $clog2(NUM_REGS);

  // index 3 first in the concatenation
  localparam logic [NUM_REGS-1:0][WORD_W-1:0] CFG_DEFAULTS = {
    32'h0000_0027, 32'hDB6D_B4A2, 32'h0000_007D, 32'h0007_F1FC};
  localparam logic [NUM_REGS-1:0][WORD_W-1:0] CFG_WR_MASK = {
    32'h0000_0A7F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF};

  localparam int unsigned REF_DIV_LSB  = 2;
  localparam int unsigned REF_DIV_W    = 10;
  localparam int unsigned FB_DIV_LSB   = 12;
  localparam int unsigned FB_DIV_W     = 12;
  localparam int unsigned AUTO_BIT     = 30;
  localparam int unsigned MUX_W        = 3;
  localparam int unsigned FB_MUX_LSB   = 10;
  localparam int unsigned N_OUT        = 5;
  localparam int unsigned OUT_MUX_LSB  = 13;
  localparam int unsigned LOCK_WIN_LSB = 2;
  localparam int unsigned LOCK_CNT_LSB = 4;
  localparam int unsigned HOLD_BIT     = 9;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned     W       = 1,
  parameter int unsigned     STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= {STAGES{RST_VAL}};
    else         q <= {q[STAGES-2:0], d_i};
  end

  assign q_o = q[STAGES-1];
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,   // synchronized
  input  logic              sdata_i,  // synchronized
  input  logic              le_i,     // synchronized
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o,
  output logic              frame_err_o
);
  localparam int unsigned       CNT_W    = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0]  CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0]  CNT_SAT  = CNT_W'(WORD_W + 1);

  logic              sclk_q, le_q;
  logic              sclk_rise, le_rise, le_fall;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic              vld_q, err_q;

  assign sclk_rise = sclk_i & ~sclk_q;
  assign le_rise   = le_i & ~le_q;
  assign le_fall   = ~le_i & le_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      le_q    <= 1'b1;
      cnt_q   <= '0;
      shift_q <= '0;
      vld_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      le_q   <= le_i;
      if (le_fall) begin
        cnt_q <= '0;
      end else if (sclk_rise && !le_i) begin
        shift_q <= {shift_q[WORD_W-2:0], sdata_i};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + CNT_W'(1);  // saturate past full
      end
      vld_q <= le_rise && (cnt_q == CNT_FULL);
      err_q <= le_rise && (cnt_q != CNT_FULL);
    end
  end

  assign word_o      = shift_q;
  assign word_vld_o  = vld_q;
  assign frame_err_o = err_q;

  AST_IGNORE_WHILE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (le_i && le_q) |=> ($stable(shift_q) && $stable(cnt_q)));  // R3
  AST_COMMIT_FULL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q |-> ($past(cnt_q) == CNT_FULL));  // R5
  AST_FRAME_START_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_fall |=> (cnt_q == '0));  // R4
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int unsigned NUM_REGS = 4,
  parameter int unsigned WORD_W   = 32,
  parameter logic [NUM_REGS-1:0][WORD_W-1:0] DEFAULTS = '0,
  parameter logic [NUM_REGS-1:0][WORD_W-1:0] WR_MASK  = '1
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             pd_ni,    // synchronized
  input  logic                             wr_vld_i,
  input  logic [WORD_W-1:0]                wr_word_i,
  input  logic                             frame_err_i,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  cfg_o,
  output logic                             err_o
);
  localparam int unsigned ADDR_W = $clog2(NUM_REGS);

  logic [NUM_REGS-1:0][WORD_W-1:0] cfg_q;
  logic                            err_q;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cfg_q[r] <= DEFAULTS[r];
      else if (!pd_ni) cfg_q[r] <= DEFAULTS[r];
      else if (wr_vld_i && (wr_word_i[ADDR_W-1:0] == ADDR_W'(r)))
        cfg_q[r] <= wr_word_i & WR_MASK[r];
    end

    AST_ONLY_ADDRESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pd_ni && !(wr_vld_i && (wr_word_i[ADDR_W-1:0] == ADDR_W'(r))))
        |=> $stable(cfg_q[r]));  // R2
    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[r] & ~WR_MASK[r]) == '0);  // R8
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          err_q <= 1'b0;
    else if (!pd_ni)      err_q <= 1'b0;
    else if (frame_err_i) err_q <= 1'b1;
  end

  assign cfg_o = cfg_q;
  assign err_o = err_q;

  AST_PD_DEFAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> ((cfg_q == DEFAULTS) && !err_q));  // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && pd_ni) |=> err_q);  // R5
endmodule

// File: rtl/cfg_serial_bank.sv
module cfg_serial_bank
  import cfg_pkg::*;
(
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             pd_ni,
  input  logic                             sclk_i,
  input  logic                             sdata_i,
  input  logic                             le_i,
  output logic [NUM_REGS-1:0][WORD_W-1:0]  cfg_o,
  output logic [REF_DIV_W-1:0]             ref_div_m1_o,
  output logic [FB_DIV_W-1:0]              fb_div_m1_o,
  output logic                             ref_auto_o,
  output logic [MUX_W-1:0]                 fb_mux_o,
  output logic [N_OUT*MUX_W-1:0]           out_mux_o,
  output logic [1:0]                       lock_win_o,
  output logic [1:0]                       lock_cnt_o,
  output logic                             hold_en_o,
  output logic                             frame_err_o
);
  logic [2:0]        pins_s;  // {le, sdata, sclk}
  logic              pd_s;
  logic [WORD_W-1:0] rx_word;
  logic              rx_vld, rx_err;
  logic [NUM_REGS-1:0][WORD_W-1:0] cfg;

  cfg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_pin_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({le_i, sdata_i, sclk_i}),
    .q_o    (pins_s)
  );

  cfg_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_pd_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pd_ni),
    .q_o    (pd_s)
  );

  cfg_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_i      (pins_s[0]),
    .sdata_i     (pins_s[1]),
    .le_i        (pins_s[2]),
    .word_o      (rx_word),
    .word_vld_o  (rx_vld),
    .frame_err_o (rx_err)
  );

  cfg_reg_bank #(
    .NUM_REGS (NUM_REGS),
    .WORD_W   (WORD_W),
    .DEFAULTS (CFG_DEFAULTS),
    .WR_MASK  (CFG_WR_MASK)
  ) u_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pd_ni       (pd_s),
    .wr_vld_i    (rx_vld),
    .wr_word_i   (rx_word),
    .frame_err_i (rx_err),
    .cfg_o       (cfg),
    .err_o       (frame_err_o)
  );

  assign cfg_o        = cfg;
  assign ref_div_m1_o = cfg[0][REF_DIV_LSB +: REF_DIV_W];
  assign fb_div_m1_o  = cfg[0][FB_DIV_LSB +: FB_DIV_W];
  assign ref_auto_o   = cfg[0][AUTO_BIT];
  assign fb_mux_o     = cfg[2][FB_MUX_LSB +: MUX_W];
  assign out_mux_o    = cfg[2][OUT_MUX_LSB +: N_OUT*MUX_W];
  assign lock_win_o   = cfg[3][LOCK_WIN_LSB +: 2];
  assign lock_cnt_o   = cfg[3][LOCK_CNT_LSB +: 2];
  assign hold_en_o    = cfg[3][HOLD_BIT];
endmodule

// File: tb/cfg_serial_bank_tb_top.sv
`timescale 1ns/1ps
module cfg_serial_bank_tb_top;
  logic clk = 1'b0;
  logic rst_ni, pd_ni, sclk, sdata, le;
  logic [3:0][31:0] cfg;
  logic [9:0]  ref_div;
  logic [11:0] fb_div;
  logic        ref_auto, hold_en, ferr;
  logic [2:0]  fb_mux;
  logic [14:0] out_mux;
  logic [1:0]  lock_win, lock_cnt;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] model [4];

  // upper half: word sent, lower half: value expected in the addressed register
  localparam logic [63:0] VEC [8] = '{
    {32'h1234_5678, 32'h1234_5678},
    {32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {32'hFFFF_FFFE, 32'hFFFF_FFFE},
    {32'hFFFF_FFFF, 32'h0000_0A7F},
    {32'h0000_0000, 32'h0000_0000},
    {32'h00FF_FFFC, 32'h00FF_FFFC},
    {32'h8000_0003, 32'h0000_0003},
    {32'h0000_0001, 32'h0000_0001}
  };

  always #2.5 clk = ~clk;

  cfg_serial_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni),
    .sclk_i(sclk), .sdata_i(sdata), .le_i(le),
    .cfg_o(cfg), .ref_div_m1_o(ref_div), .fb_div_m1_o(fb_div),
    .ref_auto_o(ref_auto), .fb_mux_o(fb_mux), .out_mux_o(out_mux),
    .lock_win_o(lock_win), .lock_cnt_o(lock_cnt), .hold_en_o(hold_en),
    .frame_err_o(ferr)
  );

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    for (int r = 0; r < 4; r++) check(tag, cfg[r], model[r]);
  endtask

  task automatic check_fields();
    check("R9 ref_div", 32'(ref_div),  32'(model[0][11:2]));
    check("R9 fb_div",  32'(fb_div),   32'(model[0][23:12]));
    check("R9 auto",    32'(ref_auto), 32'(model[0][30]));
    check("R9 fb_mux",  32'(fb_mux),   32'(model[2][12:10]));
    check("R9 out_mux", 32'(out_mux),  32'(model[2][27:13]));
    check("R9 lock_win",32'(lock_win), 32'(model[3][3:2]));
    check("R9 lock_cnt",32'(lock_cnt), 32'(model[3][5:4]));
    check("R9 hold",    32'(hold_en),  32'(model[3][9]));
  endtask

  task automatic load_defaults();
    model[0] = 32'h0007_F1FC;
    model[1] = 32'h0000_007D;
    model[2] = 32'hDB6D_B4A2;
    model[3] = 32'h0000_0027;
  endtask

  // one frame of n bits, MSB (bit n-1) first, each level held 4 clocks
  task automatic send_bits(input logic [63:0] d, input int n);
    le = 1'b0;
    wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdata = d[i];
      wait_clk(4);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    le = 1'b1;
    wait_clk(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pd_ni = 1'b1; sclk = 1'b0; sdata = 1'b0; le = 1'b1;
    load_defaults();
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(5);

    // R6 reset state, R9 default decode
    check_regs("R6 reset");
    check("R6 err", 32'(ferr), 32'd0);
    check("R9 ref_div default 127", 32'(ref_div), 32'd127);
    check("R9 fb_div default 127",  32'(fb_div),  32'd127);
    check("R9 out_mux default",     32'(out_mux), 32'h5B6D);

    // R1 R2 R8 R9 vector walk
    foreach (VEC[v]) begin
      send_bits({32'h0, VEC[v][63:32]}, 32);
      model[VEC[v][33:32]] = VEC[v][31:0];
      check_regs("R1 R2 R8 vector");
      check_fields();
      check("R5 no err on 32 bits", 32'(ferr), 32'd0);
    end

    // R3: serial clocks with latch enable high
    for (int i = 0; i < 40; i++) begin
      sdata = i[0];
      wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(10);
    check_regs("R3 ignored while high");
    check("R3 err untouched", 32'(ferr), 32'd0);

    // R5 short frame
    send_bits({32'h0, 32'h5555_5554}, 31);
    check_regs("R5 short frame");
    check("R5 err short", 32'(ferr), 32'd1);

    // R5 long frame
    send_bits({31'h0, 33'h1_0F0F_0F0F}, 33);
    check_regs("R5 long frame");
    check("R5 err long", 32'(ferr), 32'd1);

    // R4 next correct frame commits, R5 flag sticky
    send_bits({32'h0, 32'hCAFE_0002}, 32);
    model[2] = 32'hCAFE_0002;
    check_regs("R4 frame after error");
    check("R5 err sticky", 32'(ferr), 32'd1);

    // R7 power-down with a frame sent meanwhile
    pd_ni = 1'b0;
    wait_clk(5);
    send_bits({32'h0, 32'h1111_1110}, 32);
    pd_ni = 1'b1;
    wait_clk(5);
    load_defaults();
    check_regs("R7 power-down defaults");
    check("R7 err cleared", 32'(ferr), 32'd0);
    check_fields();

    summary();
    $finish;
  end
endmodule